// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block moves 18-bit words between an A side and a B side, with one storage path for each direction. Each path can act as a transparent latch, as a holding register, or as a register that loads on the falling edge of its own port clock. The mode is set by that direction's latch-enable and by whether its port clock is moving. The two directions do not share any control.

Each side is modelled as a separate input word, an output word and an output-enable flag. A pad ring or a simulation wrapper can combine these into a tri-state bus. The output enables have opposite polarities: the A-to-B enable is active high and the B-to-A enable is active low.

The whole block runs on one fast system clock. The latch is emulated by loading the input on every system clock while latch-enable is high. Each port clock is synchronized and watched for a 1-to-0 change.

Top module: `univ_xcvr`

## Requirements
- R1: The word width is 18 bits by default, and the two directions work independently: the controls of one direction never change the storage or outputs of the other.
- R2: While a direction's latch-enable is high, its storage takes that direction's input word on every system-clock edge, so the stored word trails the input by one system cycle.
- R3: While latch-enable is low and no falling port-clock edge has been detected, the stored word keeps its value, whatever the input does.
- R4: With latch-enable low, a port-clock fall is detected when one system-clock edge samples the port clock high and the next edge samples it low. Two system-clock edges after that first low sample, the storage loads the input word present at that edge.
- R5: A rising port-clock edge never loads the storage.
- R6: The A-to-B enable is active high. When it is high and reset is released, `b_oe` is 1 and `b_out` shows the A-to-B storage; otherwise `b_oe` is 0 and `b_out` is all zeros.
- R7: The B-to-A enable is active low. When it is 0 and reset is released, `a_oe` is 1 and `a_out` shows the B-to-A storage; otherwise `a_oe` is 0 and `a_out` is all zeros.
- R8: A synchronous active-low reset clears both storages and the port-clock history to zero. While reset is low, both output enables are 0.
- R9: When both enables are active at the same time, both sides are driven at once.
- R10: A detected port-clock fall while latch-enable is high stores the same word as transparent mode would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 18 | Word arriving on the A side |
| b_in | input | 18 | Word arriving on the B side |
| ab_le | input | 1 | A-to-B latch-enable |
| ab_clk | input | 1 | A-to-B port clock, loads on its fall |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch-enable |
| ba_clk | input | 1 | B-to-A port clock, loads on its fall |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_out | output | 18 | Word driven onto the A side |
| a_oe | output | 1 | A side is driven |
| b_out | output | 18 | Word driven onto the B side |
| b_oe | output | 1 | B side is driven |

## Verification
A stale or wrongly loaded storage word shows on the enabled output one system cycle after the edge that should have set it. The bench compares both outputs on every cycle, so the error is caught within that cycle. A miscounted synchronizer depth makes a port-clock capture land one cycle early or late. Data that changes right after the port clock falls shows such a shift as a mismatch. A swapped enable polarity shows at once on the output-enable flags, because those follow the control inputs without a register.

// File: rtl/xcvr_pkg.sv
// Package: shared constants for the universal transceiver.
// Assumes: direction index 0 is A-to-B, index 1 is B-to-A.
package xcvr_pkg;
    localparam int DIR_AB  = 0;
    localparam int DIR_BA  = 1;
    localparam int N_DIRS  = 2;
    localparam int DEF_W   = 18;
    localparam int DEF_SYN = 2;
endpackage

// File: rtl/xcvr_fall_det.sv
// Module: synchronizes one port clock into the system domain and flags a
// 1-to-0 change of the synchronized level for exactly one cycle.
// Assumes: the port clock is slow relative to clk (each level held >= 2 cycles).
module xcvr_fall_det #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pclk,
    output logic fall
);
    localparam int LEN = SYNC + 1;

    logic [LEN-1:0] hist;

    // Shift the port clock through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[LEN-2:0], pclk};
    end

    assign fall = hist[LEN-1] & ~hist[LEN-2];

    // R4: a fall pulse lasts a single cycle
    single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/xcvr_store.sv
// Module: one direction's storage, acting as a latch (le high) or as a
// register loaded by a detected port-clock fall (le low).
// Assumes: fall is a one-cycle pulse in the clk domain.
module xcvr_store #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         fall,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Load on transparency or on a detected fall; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          q <= '0;
        else if (le || fall) q <= d;
    end

    // R2
    transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> q == $past(d));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !fall) |=> $stable(q));
    // R4
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && fall) |=> q == $past(d));
    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> q == '0);
endmodule

// File: rtl/xcvr_lane.sv
// Module: one complete direction, made of the clock-fall detector and the storage.
// Assumes: all inputs are synchronous to clk except pclk.
module xcvr_lane #(
    parameter int W    = 18,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         pclk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic fall;

    xcvr_fall_det #(.SYNC(SYNC)) i_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .pclk  (pclk),
        .fall  (fall)
    );

    xcvr_store #(.W(W)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le),
        .fall  (fall),
        .d     (d),
        .q     (q)
    );
endmodule

// File: rtl/univ_xcvr.sv
// Module: two-direction registered bus transceiver, A-to-B and B-to-A.
// Assumes: the surrounding logic turns each out/oe pair into a tri-state bus;
// a disabled output word is forced to zero.
module univ_xcvr
    import xcvr_pkg::*;
#(
    parameter int W    = DEF_W,
    parameter int SYNC = DEF_SYN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ab_oe,
    input  logic         ba_le,
    input  logic         ba_clk,
    input  logic         ba_oe_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic [N_DIRS-1:0][W-1:0] din;
    logic [N_DIRS-1:0][W-1:0] q;
    logic [N_DIRS-1:0]        le;
    logic [N_DIRS-1:0]        pclk;

    assign din[DIR_AB]  = a_in;
    assign din[DIR_BA]  = b_in;
    assign le[DIR_AB]   = ab_le;
    assign le[DIR_BA]   = ba_le;
    assign pclk[DIR_AB] = ab_clk;
    assign pclk[DIR_BA] = ba_clk;

    for (genvar g = 0; g < N_DIRS; g++) begin : g_lane
        xcvr_lane #(.W(W), .SYNC(SYNC)) i_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .le    (le[g]),
            .pclk  (pclk[g]),
            .d     (din[g]),
            .q     (q[g])
        );
    end

    // Opposite-polarity enables, both held off during reset.
    assign b_oe  = rst_n & ab_oe;
    assign a_oe  = rst_n & ~ba_oe_n;
    assign b_out = b_oe ? q[DIR_AB] : '0;
    assign a_out = a_oe ? q[DIR_BA] : '0;

    // R6
    b_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_oe |-> b_out == '0);
    // R7
    a_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_oe |-> a_out == '0);
    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!a_oe && !b_oe));
    // R9
    both_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_oe && !ba_oe_n) |-> (a_oe && b_oe));
endmodule

// File: tb/test_univ_xcvr.sv
module test_univ_xcvr;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ab_le = 1'b0, ab_clk = 1'b0, ab_oe = 1'b0;
    logic         ba_le = 1'b0, ba_clk = 1'b0, ba_oe_n = 1'b1;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int    n_cmp = 0, n_bad = 0;
    string req = "R8";
    bit    done = 0;

    logic [W-1:0] m_ab = '0, m_ba = '0;
    bit h_ab[$] = '{0, 0, 0};
    bit h_ba[$] = '{0, 0, 0};

    always #4 clk = ~clk;

    univ_xcvr i_univ_xcvr (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
        .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    // Reference model: history queues of sampled port clocks, stored words.
    always @(posedge clk) begin
        bit f_ab, f_ba;
        if (!rst_n) begin
            m_ab = '0; m_ba = '0;
            h_ab = '{0, 0, 0}; h_ba = '{0, 0, 0};
        end else begin
            f_ab = h_ab[2] && !h_ab[1];
            f_ba = h_ba[2] && !h_ba[1];
            if (ab_le || f_ab) m_ab = a_in;
            if (ba_le || f_ba) m_ba = b_in;
            h_ab.push_front(ab_clk); void'(h_ab.pop_back());
            h_ba.push_front(ba_clk); void'(h_ba.pop_back());
        end
    end

    task automatic check(string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every port output on each falling system edge.
    always @(negedge clk) begin
        logic eb, ea;
        if (!done) begin
            eb = rst_n && ab_oe;
            ea = rst_n && !ba_oe_n;
            check("b_oe", {17'd0, b_oe}, {17'd0, eb});
            check("a_oe", {17'd0, a_oe}, {17'd0, ea});
            check("b_out", b_out, eb ? m_ab : '0);
            check("a_out", a_out, ea ? m_ba : '0);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R8: reset with enables requested and live data
        req = "R8"; ab_oe = 1; ba_oe_n = 0; ab_le = 1; ba_le = 1;
        a_in = 18'h1ABCD; b_in = 18'h2F00F;
        step(3);
        rst_n = 1;
        // R9, R2: both driven, transparent in both directions
        req = "R2";
        for (int i = 0; i < 6; i++) begin
            a_in = 18'h3FFFF ^ (18'(i) << 3); b_in = 18'h00155 + 18'(i); step(1);
        end
        req = "R9"; step(2);
        // R3: hold with steady port clocks at both levels
        req = "R3"; ab_le = 0; ba_le = 0; step(1);
        a_in = 18'h0AAAA; b_in = 18'h15555; step(4);
        ab_clk = 1; ba_clk = 1; step(4);
        a_in = 18'h01111; b_in = 18'h02222; step(4);
        // R4: falling edge captures, data changes right after capture
        req = "R4"; a_in = 18'h12345; b_in = 18'h06789; ab_clk = 0; step(2);
        a_in = 18'h0F0F0; b_in = 18'h30303; step(1);
        a_in = 18'h00001; b_in = 18'h20000; step(4);
        // R5: rising edge does not capture
        req = "R5"; a_in = 18'h3C3C3; b_in = 18'h01F1F; ab_clk = 1; ba_clk = 1; step(6);
        // R1: one direction clocked, other steady
        req = "R1"; a_in = 18'h2AAAA; ab_clk = 0; step(6);
        // R10: fall while latch-enable is high
        req = "R10"; ab_le = 1; ba_le = 1; ab_clk = 1; ba_clk = 1; step(4);
        ab_clk = 0; ba_clk = 0; a_in = 18'h0BEEF; b_in = 18'h1CAFE; step(5);
        // R6, R7: enable polarity
        req = "R6"; ab_oe = 0; step(3); ab_oe = 1; step(2);
        req = "R7"; ba_oe_n = 1; step(3); ba_oe_n = 0; step(2);
        // R1: random traffic on all controls
        req = "R1";
        for (int i = 0; i < 3000; i++) begin
            a_in = 18'($urandom); b_in = 18'($urandom);
            if ($urandom_range(0, 7) == 0) ab_le = ~ab_le;
            if ($urandom_range(0, 7) == 0) ba_le = ~ba_le;
            if (i % 5 == 0) ab_clk = ~ab_clk;
            if (i % 7 == 0) ba_clk = ~ba_clk;
            if ($urandom_range(0, 15) == 0) ab_oe = ~ab_oe;
            if ($urandom_range(0, 15) == 0) ba_oe_n = ~ba_oe_n;
            step(1);
        end
        // R8: reset in mid-run with a high port clock
        req = "R8"; ab_clk = 1; ba_clk = 1; ab_oe = 1; ba_oe_n = 0; rst_n = 0; step(2);
        rst_n = 1; ab_le = 0; ba_le = 0; step(3);
        req = "R4"; ab_clk = 0; ba_clk = 0; step(5);
        finish_run();
    end
endmodule